// File: doc/BRIEF.md
# Reloading Down-Counter Tick Timer

This block is a periodic tick source for a processor subsystem. A 24-bit counter steps down by one on each selected tick while the timer is enabled. Once it reaches zero, the next tick loads it from a software-programmed reload value, so one period lasts reload+1 ticks. Each such wrap latches a sticky flag. When interrupts are enabled, each wrap also produces a single-cycle interrupt pulse.

Software uses three word registers on a simple synchronous bus. A control/status word holds the run enable, the interrupt enable, the tick-source select and the read-only wrap flag. The other two registers hold the reload value and the current count. Any write to the count register zeroes it and drops the flag, which restarts the period. Reading the control/status word clears the flag. Together these two side effects let software acknowledge ticks and resynchronise the timer without stopping it. The tick source is either every core clock or only the cycles on which an external reference enable is high.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word, the reload register and the count all read zero, and irq_pulse is low.
- R2: While enabled, each tick lowers a nonzero count by one. A tick at zero loads the reload value. Starting from zero, the count after k ticks is reload-((k-1) mod (reload+1)).
- R3: A write of any data to the count register (byte offset 0x8) sets the count to zero and clears the wrap flag. The following tick loads the reload value, and no wrap is recorded for that load.
- R4: The control word (offset 0x0) holds enable in bit 0, interrupt enable in bit 1 and source select in bit 2. The wrap flag sits in bit 16 and cannot be written. All other control bits read zero. The reload register (offset 0x4) and the count read zero in bits 31..24, and written data there is ignored.
- R5: A wrap is the load from zero that follows a count reaching zero by counting down. A wrap sets the wrap flag. A read of the control word returns the flag and then clears it. A wrap in the same cycle as that read leaves the flag set.
- R6: irq_pulse is high for exactly one cycle after each wrap that occurs while interrupt enable is 1. It stays low otherwise.
- R7: With enable at 0 the count holds its value. The other control bits keep their written values.
- R8: With source select 1 the timer ticks on every clock. With source select 0 it ticks only on clocks where ref_tick_en is 1.
- R9: With a reload value of zero the count stays at zero, and neither the flag nor the interrupt is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| ref_tick_en | input | 1 | External reference tick enable |
| irq_pulse | output | 1 | One-cycle interrupt pulse per wrap |

## Verification
The hardest case to reach from the ports is a wrap in the same clock cycle as a control-word read. That read must return the old flag while the flag still ends up set. The bench clears the count with a write, counts exactly reload+1 idle cycles so the read lands on the wrap edge, and then reads the flag again. Randomised runs stop the timer with a read-modify-write disable after a random number of core-clock or reference-gated ticks. They also insert a resynchronising count write mid-run. The bench compares the frozen count, the flag and the number of interrupt pulses with values derived from the tick count.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 24;
  localparam int ADDR_W   = 4;
  localparam int WORD_LSB = 2;

  localparam int BIT_EN   = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 16;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic src;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tick_source.sv
module tick_source (
  input  logic en,
  input  logic src_core,
  input  logic ref_tick_en,
  output logic tick
);
  always_comb begin
    tick = en & (src_core | ref_tick_en);
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic hit_zero;
  logic at_zero;

  assign at_zero = (cnt == ZERO);
  assign wrap    = tick & ~clr & at_zero & (reload != ZERO) & hit_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= ZERO;
      hit_zero <= 1'b0;
    end else if (clr) begin
      cnt      <= ZERO;
      hit_zero <= 1'b0;
    end else if (tick) begin
      if (at_zero) begin
        if (reload != ZERO) begin
          cnt      <= reload;
          hit_zero <= 1'b0;
        end
      end else begin
        cnt      <= cnt - ONE;
        hit_zero <= (cnt == ONE);
      end
    end
  end

  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && !at_zero) |=> (cnt == $past(cnt) - ONE)); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == ZERO)); // R3

  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt)); // R7

  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (at_zero && reload == ZERO) |=> (cnt == ZERO)); // R9
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [CW-1:0] cnt,
  input  logic          wrap,
  output ctrl_t         ctrl,
  output logic [CW-1:0] reload,
  output logic          clr
);
  localparam int PAD_W = DW - CW;

  reg_sel_e  which;
  logic      do_wr;
  logic      do_rd;
  logic      flag;
  logic [DW-1:0] ctrl_word;
  logic      unused_bits;

  assign which       = reg_sel_e'(addr[WORD_LSB +: 2]);
  assign do_wr       = sel & wr;
  assign do_rd       = sel & ~wr;
  assign clr         = do_wr && (which == SEL_COUNT);
  assign unused_bits = ^{wdata[DW-1:BIT_SRC+1], addr[WORD_LSB-1:0]};

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[BIT_EN]   = ctrl.en;
    ctrl_word[BIT_IE]   = ctrl.ie;
    ctrl_word[BIT_SRC]  = ctrl.src;
    ctrl_word[BIT_FLAG] = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      reload <= '0;
    end else if (do_wr) begin
      case (which)
        SEL_CTRL: begin
          ctrl.en  <= wdata[BIT_EN];
          ctrl.ie  <= wdata[BIT_IE];
          ctrl.src <= wdata[BIT_SRC];
        end
        SEL_RELOAD: reload <= wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (wrap) begin
      flag <= 1'b1;
    end else if (clr || (do_rd && which == SEL_CTRL)) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (do_rd) begin
      case (which)
        SEL_CTRL:   rdata <= ctrl_word;
        SEL_RELOAD: rdata <= {{PAD_W{1'b0}}, reload};
        SEL_COUNT:  rdata <= {{PAD_W{1'b0}}, cnt};
        default:    rdata <= '0;
      endcase
    end else begin
      rdata <= '0;
    end
  end

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag); // R5

  AST_CLR_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (clr && !wrap) |=> !flag); // R3
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ref_tick_en,
  output logic          irq_pulse
);
  ctrl_t         ctrl;
  logic [CW-1:0] reload;
  logic [CW-1:0] cnt;
  logic          clr;
  logic          tick;
  logic          wrap;

  tick_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .cnt(cnt), .wrap(wrap),
    .ctrl(ctrl), .reload(reload), .clr(clr)
  );

  tick_source u_src (
    .en(ctrl.en), .src_core(ctrl.src), .ref_tick_en(ref_tick_en), .tick(tick)
  );

  tick_counter #(.CNT_W(CW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clr(clr), .reload(reload),
    .cnt(cnt), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_pulse <= 1'b0;
    else     irq_pulse <= wrap & ctrl.ie;
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(ctrl.ie)); // R6

  AST_SRC_GATE: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && !ctrl.src && !ref_tick_en && !clr) |=> $stable(cnt)); // R8
endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ref_tick_en = 1'b0;
  logic        irq_pulse;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_tick_en(ref_tick_en), .irq_pulse(irq_pulse)
  );

  always @(posedge clk) begin
    #5;
    if (!rst && irq_pulse) irq_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int exp_count(input int r, input int k);
    if (r == 0 || k == 0) return 0;
    return r - ((k - 1) % (r + 1));
  endfunction

  function automatic int exp_wraps(input int r, input int k);
    if (r == 0 || k == 0) return 0;
    return (k - 1) / (r + 1);
  endfunction

  // idle cycles with random reference ticks, returns number of ticks seen
  task automatic run_idle(input int n, input bit src, output int ticks);
    ticks = 0;
    for (int i = 0; i < n; i++) begin
      ref_tick_en = $urandom_range(0, 1);
      if (src || ref_tick_en) ticks++;
      @(negedge clk);
    end
    ref_tick_en = 1'b0;
  endtask

  task automatic run_case(input int r, input bit src, input bit ie, input int n1, input int n2, input string tag);
    logic [31:0] rd, rd2;
    logic [31:0] cbits;
    int t, k, base, w;
    cbits = {29'd0, src, ie, 1'b0};
    bwrite(4'h4, {8'($urandom), 24'(r)});
    bwrite(4'h0, cbits | 32'h1);
    run_idle(n1, src, t);
    bwrite(4'h8, $urandom);            // R3 resync clear mid-run
    base = irq_cnt;
    run_idle(n2, src, t);
    bwrite(4'h0, cbits);               // read-modify-write style disable
    k = src ? t + 1 : t;               // core clock also ticks on the disable edge
    w = exp_wraps(r, k);
    idle(3);
    bread(4'h8, rd);
    chk(rd == 32'(exp_count(r, k)), {tag, " R2 R3 R8 count"}, rd, 32'(exp_count(r, k)));
    idle(6);
    bread(4'h8, rd2);
    chk(rd2 == rd, "R7 count frozen while disabled", rd2, rd);
    bread(4'h0, rd);
    chk(rd == (cbits | (w > 0 ? 32'h10000 : 32'h0)), {tag, " R5 R7 status"}, rd,
        cbits | (w > 0 ? 32'h10000 : 32'h0));
    bread(4'h0, rd);
    chk(rd == cbits, "R5 flag cleared by status read", rd, cbits);
    chk((irq_cnt - base) == (ie ? w : 0), {tag, " R6 irq pulses"}, 32'(irq_cnt - base), 32'(ie ? w : 0));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int base;
    void'($urandom(32'd20240611));
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(irq_pulse == 1'b0, "R1 irq low", 32'(irq_pulse), 32'd0);
    bread(4'h0, rd); chk(rd == 32'h0, "R1 control", rd, 32'h0);
    bread(4'h4, rd); chk(rd == 32'h0, "R1 reload", rd, 32'h0);
    bread(4'h8, rd); chk(rd == 32'h0, "R1 count", rd, 32'h0);
    // R4 field masking
    bwrite(4'h4, 32'hFFFF_FFFF);
    bread(4'h4, rd); chk(rd == 32'h00FF_FFFF, "R4 reload upper bits", rd, 32'h00FF_FFFF);
    bwrite(4'h0, 32'hFFFF_FFF8);
    bread(4'h0, rd); chk(rd == 32'h0, "R4 control reserved/flag not writable", rd, 32'h0);
    bwrite(4'h0, 32'h0000_0006);
    bread(4'h0, rd); chk(rd == 32'h6, "R4 control bit positions", rd, 32'h6);
    bwrite(4'h0, 32'h0);
    // directed: exact period, reload zero, reference gating
    run_case(3, 1'b1, 1'b1, 0, 8, "dir-period");
    run_case(0, 1'b1, 1'b1, 5, 30, "dir-R9");
    run_case(1, 1'b0, 1'b1, 4, 40, "dir-ref");
    run_case(5, 1'b1, 1'b0, 3, 25, "dir-noie");
    // R5 wrap coinciding with a status read
    bwrite(4'h4, 32'd3);
    bwrite(4'h0, 32'h7);
    bwrite(4'h8, 32'h0);
    base = irq_cnt;
    idle(4);
    bread(4'h0, rd);                   // sampled on the wrap edge (5th tick)
    chk(rd == 32'h7, "R5 read on wrap returns old flag", rd, 32'h7);
    bwrite(4'h0, 32'h6);
    idle(2);
    bread(4'h0, rd);
    chk(rd == 32'h0001_0006, "R5 wrap wins over read clear", rd, 32'h0001_0006);
    chk((irq_cnt - base) == 1, "R6 single pulse for coinciding wrap", 32'(irq_cnt - base), 32'd1);
    bread(4'h8, rd);
    chk(rd == 32'd2, "R2 count after wrap", rd, 32'd2);
    // random runs
    for (int it = 0; it < 40; it++) begin
      run_case($urandom_range(0, 12), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               $urandom_range(0, 30), $urandom_range(0, 60), "rand");
    end
    finish_run();
  end
endmodule